// File: doc/BRIEF.md
# Dual-Width I2C Slave Address Recognizer

This block decides whether an I2C slave device is being addressed. A separate bit-level engine samples the bus and hands it decoded events: a START, a repeated START, a STOP, and an end-of-byte strobe that carries the byte just shifted in. From these events the recognizer drives four signals. The first is an acknowledge request for the ninth clock. The others are flags for "selected", "slave transmits" and "general call".

A configuration input picks the slave's address width. In ten-bit mode, matching is spread over two bytes. The first byte carries a header tag plus the two high address bits and the direction bit. The second byte carries the low eight address bits. The recognizer remembers a completed ten-bit match across a repeated START. That lets the master turn the slave into a transmitter by sending only the header again with the read bit set. In seven-bit mode a single byte decides, and header-tagged bytes never match. The general call and the START byte are recognized in both modes. Bytes after selection pass through without acknowledgement, since data handling belongs to the bit engine.

Top module: `i2c_addr_match`

## Requirements
- R1: Out of reset `ack_req`, `addr_sel`, `slave_tx` and `gcall_sel` are all low.
- R2: In ten-bit mode, after START a byte `11110` + `own_addr[9:8]` + `0` is acknowledged without selecting. A following byte equal to `own_addr[7:0]` is acknowledged, and one cycle later `addr_sel`=1 and `slave_tx`=0.
- R3: If the header matched but the second byte differs from `own_addr[7:0]`, nothing is acknowledged and the slave stays unselected. Every later byte is ignored until the next START or repeated START.
- R4: After a completed ten-bit match, a repeated START followed by the same header with bit 0 = 1 is acknowledged. One cycle later `addr_sel`=1 and `slave_tx`=1, with no second address byte.
- R5: A plain START erases the memory of an earlier ten-bit match. A header with bit 0 = 1 after a plain START is then neither acknowledged nor selects.
- R6: A selection stays in force through a repeated START until the next address byte. STOP clears `addr_sel`, `slave_tx` and `gcall_sel` one cycle later, and an address byte for another device after a repeated START clears them as well.
- R7: In ten-bit mode a first byte with upper bits `11111` (reserved), or a header whose two address bits differ from `own_addr[9:8]`, is never acknowledged.
- R8: A first byte of `8'h00` (general call) is acknowledged in both modes. It sets `gcall_sel`=1 and leaves `addr_sel`=0.
- R9: A first byte of `8'h01` (START byte) is never acknowledged. The address phase starts over at the following repeated START.
- R10: In seven-bit mode a first byte whose bits [7:1] equal `own_addr[6:0]` is acknowledged, and `slave_tx` follows bit 0. A byte with upper bits `11110` never matches, even if it equals the own address.
- R11: `ack_req` is high only in a cycle with `byte_stb`, lasts that single cycle, and is never raised for bytes that arrive after selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ten_bit | input | 1 | 1 = ten-bit own address, 0 = seven-bit |
| own_addr | input | 10 | Own address; only bits [6:0] are used in seven-bit mode |
| ev_start | input | 1 | One-cycle START event |
| ev_rstart | input | 1 | One-cycle repeated START event |
| ev_stop | input | 1 | One-cycle STOP event |
| byte_stb | input | 1 | End-of-byte strobe, one cycle |
| byte_data | input | 8 | Received byte, valid with `byte_stb` |
| ack_req | output | 1 | Acknowledge request for the ninth clock (same cycle as strobe) |
| addr_sel | output | 1 | Slave is addressed by its own address |
| slave_tx | output | 1 | Addressed slave transmits (read transfer) |
| gcall_sel | output | 1 | General call accepted |

## Verification
The header is tried with its own high bits, with wrong high bits, and with the reserved tag. These cases separate tag decoding from address comparison. The header is followed by a matching and by a differing low byte, which separates the first and second acknowledge. Stray bytes after a mismatch show whether the slave really dropped out. The read header is sent after a repeated START and after a plain START, which tells whether the match memory survives one and is erased by the other. General call, START byte and seven-bit traffic are tried in both widths, including a seven-bit own address that equals a header pattern.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;

    localparam int BYTE_W = 8;
    localparam logic [4:0] HDR_TAG = 5'b11110;
    localparam logic [4:0] RSV_TAG = 5'b11111;
    localparam logic [7:0] GCALL_BYTE = 8'h00;
    localparam logic [7:0] SBYTE_CODE = 8'h01;

    typedef enum logic [2:0] {
        CLS_NONE,
        CLS_GCALL,
        CLS_SBYTE,
        CLS_HDR_WR,
        CLS_HDR_RD,
        CLS_SEVEN
    } byte_cls_e;

    typedef enum logic [2:0] {
        ST_FREE,
        ST_FIRST,
        ST_LOWBYTE,
        ST_SEL,
        ST_GC,
        ST_IGNORE
    } am_state_e;

    typedef struct packed {
        logic sel;
        logic tx;
        logic gc;
    } am_flags_t;

    function automatic logic is_hdr_tag(input logic [7:0] b);
        return b[7:3] == HDR_TAG;
    endfunction

    function automatic logic is_seven_reserved(input logic [7:0] b);
        return b[7:4] == 4'b1111;
    endfunction

endpackage

// File: rtl/i2c_am_classify.sv
module i2c_am_classify
    import i2c_am_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ten_bit,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [7:0]        byte_data,
    output byte_cls_e         cls,
    output logic              lo_match
);
    localparam int HI_W = ADDR_W - BYTE_W;

    logic [HI_W-1:0] own_hi;
    logic [BYTE_W-1:0] own_lo;

    assign own_hi = own_addr[ADDR_W-1:BYTE_W];
    assign own_lo = own_addr[BYTE_W-1:0];
    assign lo_match = (byte_data == own_lo);

    always_comb begin
        cls = CLS_NONE;
        if (byte_data == GCALL_BYTE) begin
            cls = CLS_GCALL;
        end else if (byte_data == SBYTE_CODE) begin
            cls = CLS_SBYTE;
        end else if (ten_bit) begin
            if (is_hdr_tag(byte_data) && byte_data[2:1] == own_hi)
                cls = byte_data[0] ? CLS_HDR_RD : CLS_HDR_WR;
        end else begin
            if (!is_seven_reserved(byte_data) && byte_data[7:1] == own_addr[6:0])
                cls = CLS_SEVEN;
        end
    end

    AST_RESERVED_NO_HDR: assert property (@(posedge clk) disable iff (rst)
        (ten_bit && byte_data[7:3] == RSV_TAG) |-> (cls == CLS_NONE)); // R7

    AST_SEVEN_NO_HDR: assert property (@(posedge clk) disable iff (rst)
        (!ten_bit && is_hdr_tag(byte_data)) |-> (cls != CLS_SEVEN)); // R10

endmodule

// File: rtl/i2c_am_fsm.sv
module i2c_am_fsm
    import i2c_am_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ev_start,
    input  logic      ev_rstart,
    input  logic      ev_stop,
    input  logic      byte_stb,
    input  logic      rw_bit,
    input  byte_cls_e cls,
    input  logic      lo_match,
    output logic      ack_req,
    output am_flags_t flags
);
    am_state_e state_q, state_d;
    am_flags_t flags_q, flags_d;
    logic      prev_q, prev_d;

    always_comb begin
        state_d = state_q;
        flags_d = flags_q;
        prev_d  = prev_q;
        ack_req = 1'b0;
        if (ev_stop) begin
            state_d = ST_FREE;
            flags_d = '0;
            prev_d  = 1'b0;
        end else if (ev_start) begin
            state_d = ST_FIRST;
            flags_d = '0;
            prev_d  = 1'b0;
        end else if (ev_rstart) begin
            state_d = ST_FIRST;
        end else if (byte_stb) begin
            unique case (state_q)
                ST_FIRST: begin
                    flags_d = '0;
                    prev_d  = 1'b0;
                    state_d = ST_IGNORE;
                    unique case (cls)
                        CLS_GCALL: begin
                            ack_req    = 1'b1;
                            flags_d.gc = 1'b1;
                            state_d    = ST_GC;
                        end
                        CLS_HDR_WR: begin
                            ack_req = 1'b1;
                            state_d = ST_LOWBYTE;
                        end
                        CLS_HDR_RD: begin
                            if (prev_q) begin
                                ack_req     = 1'b1;
                                flags_d.sel = 1'b1;
                                flags_d.tx  = 1'b1;
                                prev_d      = 1'b1;
                                state_d     = ST_SEL;
                            end
                        end
                        CLS_SEVEN: begin
                            ack_req     = 1'b1;
                            flags_d.sel = 1'b1;
                            flags_d.tx  = rw_bit;
                            state_d     = ST_SEL;
                        end
                        default: ;
                    endcase
                end
                ST_LOWBYTE: begin
                    if (lo_match) begin
                        ack_req     = 1'b1;
                        flags_d.sel = 1'b1;
                        flags_d.tx  = 1'b0;
                        prev_d      = 1'b1;
                        state_d     = ST_SEL;
                    end else begin
                        state_d = ST_IGNORE;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FREE;
            flags_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            flags_q <= flags_d;
            prev_q  <= prev_d;
        end
    end

    assign flags = flags_q;

    AST_ACK_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
        ack_req |-> byte_stb); // R11

    AST_STOP_DROPS: assert property (@(posedge clk) disable iff (rst)
        ev_stop |=> (!flags_q.sel && !flags_q.tx && !flags_q.gc)); // R6

    AST_FRESH_START_FORGETS: assert property (@(posedge clk) disable iff (rst)
        ev_start |=> !prev_q); // R5

    AST_TX_NEEDS_SEL: assert property (@(posedge clk) disable iff (rst)
        flags_q.tx |-> flags_q.sel); // R4

    AST_SEL_GC_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(flags_q.sel && flags_q.gc)); // R8

    AST_LOW_MATCH_SELECTS: assert property (@(posedge clk) disable iff (rst)
        (byte_stb && !ev_stop && !ev_start && !ev_rstart && state_q == ST_LOWBYTE && lo_match)
        |=> (flags_q.sel && !flags_q.tx)); // R2

    AST_NO_ACK_AFTER_SEL: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SEL && !ev_start && !ev_rstart && !ev_stop) |-> !ack_req); // R11

endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
    import i2c_am_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_ten_bit,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              ev_start,
    input  logic              ev_rstart,
    input  logic              ev_stop,
    input  logic              byte_stb,
    input  logic [7:0]        byte_data,
    output logic              ack_req,
    output logic              addr_sel,
    output logic              slave_tx,
    output logic              gcall_sel
);
    byte_cls_e cls;
    logic      lo_match;
    am_flags_t flags;

    i2c_am_classify #(.ADDR_W(ADDR_W)) u_classify (
        .clk      (clk),
        .rst      (rst),
        .ten_bit  (cfg_ten_bit),
        .own_addr (own_addr),
        .byte_data(byte_data),
        .cls      (cls),
        .lo_match (lo_match)
    );

    i2c_am_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .ev_start (ev_start),
        .ev_rstart(ev_rstart),
        .ev_stop  (ev_stop),
        .byte_stb (byte_stb),
        .rw_bit   (byte_data[0]),
        .cls      (cls),
        .lo_match (lo_match),
        .ack_req  (ack_req),
        .flags    (flags)
    );

    assign addr_sel  = flags.sel;
    assign slave_tx  = flags.tx;
    assign gcall_sel = flags.gc;

endmodule

// File: tb/i2c_addr_match_tb.sv
`timescale 1ns/1ps
module i2c_addr_match_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_ten_bit = 1'b1;
    logic [9:0] own_addr = 10'h2A5;
    logic       ev_start = 1'b0, ev_rstart = 1'b0, ev_stop = 1'b0;
    logic       byte_stb = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic       ack_req, addr_sel, slave_tx, gcall_sel;

    int n_checks = 0;
    int n_errors = 0;
    logic [3:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    i2c_addr_match u_dut (
        .clk(clk), .rst(rst), .cfg_ten_bit(cfg_ten_bit), .own_addr(own_addr),
        .ev_start(ev_start), .ev_rstart(ev_rstart), .ev_stop(ev_stop),
        .byte_stb(byte_stb), .byte_data(byte_data),
        .ack_req(ack_req), .addr_sel(addr_sel), .slave_tx(slave_tx), .gcall_sel(gcall_sel)
    );

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual {ack,sel,tx,gc}=%b expected %b", tag, act, exp);
        end
    endtask

    // Driver: one byte, then one idle cycle; expected result pushed to the scoreboard
    task automatic send(input logic [7:0] b, input logic a, input logic s,
                        input logic t, input logic g, input string tag);
        exp_q.push_back({a, s, t, g});
        tag_q.push_back(tag);
        @(negedge clk);
        byte_data = b;
        byte_stb  = 1'b1;
        @(negedge clk);
        byte_stb  = 1'b0;
        @(negedge clk);
    endtask

    task automatic event_start();  @(negedge clk); ev_start  = 1'b1; @(negedge clk); ev_start  = 1'b0; endtask
    task automatic event_rstart(); @(negedge clk); ev_rstart = 1'b1; @(negedge clk); ev_rstart = 1'b0; endtask

    task automatic event_stop(input logic s, input logic t, input logic g, input string tag);
        @(negedge clk); ev_stop = 1'b1;
        @(negedge clk); ev_stop = 1'b0;
        #1 check(tag, {ack_req, addr_sel, slave_tx, gcall_sel}, {1'b0, 1'b0, 1'b0, 1'b0});
    endtask

    // Monitor: ack sampled in the strobe cycle, flags one cycle later
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (byte_stb && exp_q.size() > 0) begin
                logic [3:0] e;
                string tg;
                e  = exp_q.pop_front();
                tg = tag_q.pop_front();
                check({tg, " ack"}, {3'b000, ack_req}, {3'b000, e[3]});
                @(negedge clk);
                #1;
                check({tg, " flags"}, {ack_req, addr_sel, slave_tx, gcall_sel}, {1'b0, e[2:0]});
            end
        end
    end

    int cycles = 0;
    logic done = 1'b0;
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1 check("R1 reset", {ack_req, addr_sel, slave_tx, gcall_sel}, 4'b0000);

        // Ten-bit write selection, data byte, then turnaround to transmitter
        event_start();
        send(8'hF4, 1, 0, 0, 0, "R2 header A1");
        send(8'hA5, 1, 1, 0, 0, "R2 low byte A2");
        send(8'h55, 0, 1, 0, 0, "R11 data byte not acked");
        event_rstart();
        #1 check("R6 held across Sr", {ack_req, addr_sel, slave_tx, gcall_sel}, 4'b0100);
        send(8'hF5, 1, 1, 1, 0, "R4 read header A3");
        event_stop(0, 0, 0, "R6 stop clears");

        // Fresh START forgets the earlier match
        event_start();
        send(8'hF4, 1, 0, 0, 0, "R5 header");
        send(8'hA5, 1, 1, 0, 0, "R5 low byte");
        event_start();
        send(8'hF5, 0, 0, 0, 0, "R5 read after plain START");
        event_stop(0, 0, 0, "R5 stop");
        event_start();
        send(8'hF5, 0, 0, 0, 0, "R5 read with no history");

        // Second byte mismatch
        event_start();
        send(8'hF4, 1, 0, 0, 0, "R3 header");
        send(8'h5A, 0, 0, 0, 0, "R3 low mismatch");
        send(8'hF4, 0, 0, 0, 0, "R3 ignored byte");
        send(8'h00, 0, 0, 0, 0, "R3 ignored gcall");
        event_rstart();
        send(8'hF4, 1, 0, 0, 0, "R3 recover header");
        send(8'hA5, 1, 1, 0, 0, "R3 recover low");
        event_stop(0, 0, 0, "R3 stop");

        // Reserved tag and wrong high bits
        event_start();
        send(8'hFC, 0, 0, 0, 0, "R7 reserved 11111");
        event_start();
        send(8'hF8, 0, 0, 0, 0, "R7 reserved 11111 other");
        event_start();
        send(8'hF6, 0, 0, 0, 0, "R7 wrong high bits");

        // General call
        event_start();
        send(8'h00, 1, 0, 0, 1, "R8 general call ten-bit");
        event_stop(0, 0, 0, "R8 stop");

        // START byte then restart
        event_start();
        send(8'h01, 0, 0, 0, 0, "R9 start byte");
        event_rstart();
        send(8'hF4, 1, 0, 0, 0, "R9 header after Sr");
        send(8'hA5, 1, 1, 0, 0, "R9 low after Sr");

        // Different address after Sr drops the selection
        event_rstart();
        send(8'h78, 0, 0, 0, 0, "R6 other address after Sr");
        event_rstart();
        send(8'hF5, 0, 0, 0, 0, "R6 memory lost after other address");
        event_stop(0, 0, 0, "R6 stop 2");

        // Seven-bit mode
        cfg_ten_bit = 1'b0;
        own_addr    = 10'h03C;
        event_start();
        send(8'h79, 1, 1, 1, 0, "R10 seven read");
        event_stop(0, 0, 0, "R10 stop");
        event_start();
        send(8'h78, 1, 1, 0, 0, "R10 seven write");
        send(8'h33, 0, 1, 0, 0, "R11 seven data");
        event_start();
        send(8'hF4, 0, 0, 0, 0, "R10 header in seven mode");
        event_start();
        send(8'h00, 1, 0, 0, 1, "R8 general call seven-bit");
        own_addr = 10'h07A;
        event_start();
        send(8'hF4, 0, 0, 0, 0, "R10 own equals header");
        event_start();
        send(8'h01, 0, 0, 0, 0, "R9 start byte seven-bit");
        event_stop(0, 0, 0, "R10 final stop");

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule